// File: doc/BRIEF.md
# Single-Port SECDED RAM with Optional Decoder Pipeline

This block is a single-clock, single-port synchronous memory. It stores 64-bit words as 72-bit codewords that carry single-error-correct, double-error-detect check bits. Every read passes through a decoder. The decoder repairs any single flipped bit and flags the case. A double flip is reported with its own flag. The read port has up to three register stages in a row: the array read latch, an optional decoder pipeline register, and an optional output register.

The read latch responds to a write in one of three ways, chosen at build time by a parameter:
- it returns the old word,
- it returns the new word, or
- it keeps its previous value.

The pipeline register sits in front of the decoder. It has its own clock enable and no reset. Neither reset input disturbs it. When this stage is enabled, the decoder works on the word fetched for the previous address while the array fetches the current one, and read latency grows by one cycle. The two error flags travel through the same stages as the data, so they always describe the word presented with them.

Top module: `secded_pipe_ram`

## Requirements
- R1: A word written to an address reads back unchanged with both flags low. The read result appears 1 + PIPE_EN + OUT_REG rising edges after the edge that samples the read.
- R2: With MODE = COLL_READ_FIRST, a write also returns the word that was stored at that address before the write.
- R3: With MODE = COLL_WRITE_FIRST, a write also returns the word being written.
- R4: With MODE = COLL_NO_CHANGE, a write leaves the read latch, and therefore the read result, unchanged.
- R5: Codeword bit 0 is the overall parity. Bits at positions 1, 2, 4, 8, 16, 32 and 64 are Hamming bits. The remaining positions hold data bits 0 to 63 in ascending order. Any single flipped stored bit gives the original data with err_single = 1 and err_double = 0.
- R6: Two flipped stored bits give err_double = 1 and err_single = 0, with the data bits passed uncorrected.
- R7: With PIPE_EN = 1, the pipeline register loads only while pipe_ce is high, and it holds its value otherwise.
- R8: Asserting rst_latch or rst_out leaves the pipeline register contents unchanged.
- R9: rst_latch clears the read latch to the all-zero codeword, which decodes as data 0 with both flags low.
- R10: rst_out clears the output register (data and both flags) to zero. The output register loads on every other edge.
- R11: While en is low, the read latch holds its value and memory is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| en | input | 1 | Access enable for read or write |
| we | input | 1 | Write when high, read when low (qualified by en) |
| addr | input | ADDR_W | Word address |
| wdata | input | 64 | Data to store |
| pipe_ce | input | 1 | Load enable for the decoder pipeline register |
| rst_latch | input | 1 | Synchronous clear of the array read latch |
| rst_out | input | 1 | Synchronous clear of the output register |
| rdata | output | 64 | Corrected read data |
| err_single | output | 1 | Single-bit error detected and corrected |
| err_double | output | 1 | Double-bit error detected, data uncorrected |

## Verification
Some properties are checked by the assertions on every cycle:
- the two flags are never high together;
- the no-change and write-through latch behaviour;
- each reset clears only its own stage;
- the pipeline register holds while its enable is low or a reset is applied.

Other behaviour only the bench scenarios can show, because it needs a known stored word:
- correction of specific flipped codeword bits;
- the uncorrected data returned on a double error;
- the exact read latency with and without the pipeline stage;
- the pipeline register keeping a word across a reset and presenting it afterwards.

// File: rtl/secded_ram_pkg.sv
package secded_ram_pkg;

  localparam int DATA_W = 64;
  localparam int HAM_W  = 7;
  localparam int CODE_W = DATA_W + HAM_W + 1;

  typedef enum logic [1:0] {
    COLL_READ_FIRST  = 2'd0,
    COLL_WRITE_FIRST = 2'd1,
    COLL_NO_CHANGE   = 2'd2
  } coll_mode_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              sbe;
    logic              dbe;
  } dec_res_t;

  // True for codeword positions reserved for Hamming bits.
  function automatic logic is_ham_pos(int p);
    return (p & (p - 1)) == 0;
  endfunction

  // Place data bits, then compute Hamming and overall parity.
  function automatic logic [CODE_W-1:0] secded_encode(logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] cw;
    int k;
    cw = '0;
    k  = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if (!is_ham_pos(p)) begin
        cw[p] = d[k];
        k++;
      end
    end
    for (int b = 0; b < HAM_W; b++) begin
      logic acc;
      acc = 1'b0;
      for (int p = 1; p < CODE_W; p++) begin
        if (((p >> b) & 1) == 1 && !is_ham_pos(p)) acc ^= cw[p];
      end
      cw[1 << b] = acc;
    end
    cw[0] = ^cw[CODE_W-1:1];
    return cw;
  endfunction

  // XOR of positions of all set bits above bit 0.
  function automatic logic [HAM_W-1:0] secded_syndrome(logic [CODE_W-1:0] cw);
    logic [HAM_W-1:0] s;
    s = '0;
    for (int p = 1; p < CODE_W; p++) begin
      if (cw[p]) s ^= HAM_W'(p);
    end
    return s;
  endfunction

  function automatic logic [DATA_W-1:0] secded_extract(logic [CODE_W-1:0] cw);
    logic [DATA_W-1:0] d;
    int k;
    d = '0;
    k = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if (!is_ham_pos(p)) begin
        d[k] = cw[p];
        k++;
      end
    end
    return d;
  endfunction

  function automatic dec_res_t secded_decode(logic [CODE_W-1:0] cw);
    dec_res_t r;
    logic [HAM_W-1:0] s;
    logic pm;
    logic [CODE_W-1:0] fixed;
    s     = secded_syndrome(cw);
    pm    = ^cw;
    fixed = cw;
    if (pm && s != '0 && int'(s) < CODE_W) fixed[s] = ~fixed[s];
    r.data = secded_extract(fixed);
    r.sbe  = pm;
    r.dbe  = !pm && (s != '0);
    return r;
  endfunction

endpackage

// File: rtl/secded_ram_store.sv
module secded_ram_store
  import secded_ram_pkg::*;
#(
  parameter int         DEPTH  = 16,
  parameter int         ADDR_W = $clog2(DEPTH),
  parameter coll_mode_e MODE   = COLL_READ_FIRST
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CODE_W-1:0] wcode,
  input  logic              rst_latch,
  output logic [CODE_W-1:0] rcode
);

  logic [CODE_W-1:0] mem_q [DEPTH];
  logic [CODE_W-1:0] latch_q;
  logic              wr_fire;
  logic              rd_fire;

  assign wr_fire = en && we;
  assign rd_fire = en && !we;

  always_ff @(posedge clk) begin
    if (wr_fire) mem_q[addr] <= wcode;
  end

  always_ff @(posedge clk) begin
    if (rst_latch) begin
      latch_q <= '0;
    end else if (rd_fire) begin
      latch_q <= mem_q[addr];
    end else if (wr_fire) begin
      case (MODE)
        COLL_READ_FIRST:  latch_q <= mem_q[addr];
        COLL_WRITE_FIRST: latch_q <= wcode;
        default:          latch_q <= latch_q;
      endcase
    end
  end

  assign rcode = latch_q;

  // R9: latch reset lands on zero
  a_r9_latch_clear: assert property (@(posedge clk) disable iff (1'b0)
    rst_latch |=> (rcode == '0));

  // R11: idle cycles keep the latch
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst_latch)
    !en |=> $stable(rcode));

  generate
    if (MODE == COLL_NO_CHANGE) begin : g_nc_chk
      // R4: no-change mode leaves latch on a write
      a_r4_nc_hold: assert property (@(posedge clk) disable iff (rst_latch)
        wr_fire |=> $stable(rcode));
    end else if (MODE == COLL_WRITE_FIRST) begin : g_wf_chk
      // R3: write-through presents the new codeword
      a_r3_write_through: assert property (@(posedge clk) disable iff (rst_latch)
        wr_fire |=> (rcode == $past(wcode)));
    end
  endgenerate

endmodule

// File: rtl/secded_ram_pipe.sv
module secded_ram_pipe
  import secded_ram_pkg::*;
#(
  parameter bit PIPE_EN = 1'b1
) (
  input  logic              clk,
  input  logic              ce,
  input  logic [CODE_W-1:0] d,
  output logic [CODE_W-1:0] q
);

  generate
    if (PIPE_EN) begin : g_pipe
      logic [CODE_W-1:0] pipe_q;
      always_ff @(posedge clk) begin
        if (ce) pipe_q <= d;
      end
      assign q = pipe_q;

      // R7: stage follows its enable only
      a_r7_pipe_hold: assert property (@(posedge clk) disable iff (1'b0)
        !ce |=> $stable(q));
    end else begin : g_bypass
      logic unused_ce;
      assign unused_ce = ce;
      assign q = d;
    end
  endgenerate

endmodule

// File: rtl/secded_ram_decout.sv
module secded_ram_decout
  import secded_ram_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_out,
  input  logic [CODE_W-1:0] code,
  output logic [DATA_W-1:0] rdata,
  output logic              err_single,
  output logic              err_double
);

  dec_res_t dec_now;
  dec_res_t out_res;

  assign dec_now = secded_decode(code);

  generate
    if (OUT_REG) begin : g_oreg
      dec_res_t oreg_q;
      always_ff @(posedge clk) begin
        if (rst_out) oreg_q <= '0;
        else         oreg_q <= dec_now;
      end
      assign out_res = oreg_q;

      // R10: output stage clears data and flags
      a_r10_out_clear: assert property (@(posedge clk) disable iff (1'b0)
        rst_out |=> (out_res == '0));
    end else begin : g_comb
      logic unused_rst;
      assign unused_rst = rst_out;
      assign out_res = dec_now;
    end
  endgenerate

  assign rdata      = out_res.data;
  assign err_single = out_res.sbe;
  assign err_double = out_res.dbe;

  // R5/R6: single and double flags exclusive
  a_r6_flags_excl: assert property (@(posedge clk) disable iff (rst_out)
    $onehot0({err_single, err_double}));

endmodule

// File: rtl/secded_pipe_ram.sv
module secded_pipe_ram
  import secded_ram_pkg::*;
#(
  parameter int         DEPTH   = 16,
  parameter bit         PIPE_EN = 1'b1,
  parameter bit         OUT_REG = 1'b1,
  parameter coll_mode_e MODE    = COLL_READ_FIRST,
  localparam int        ADDR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [63:0]       wdata,
  input  logic              pipe_ce,
  input  logic              rst_latch,
  input  logic              rst_out,
  output logic [63:0]       rdata,
  output logic              err_single,
  output logic              err_double
);

  logic [CODE_W-1:0] wr_code;
  logic [CODE_W-1:0] arr_code;
  logic [CODE_W-1:0] dec_in_code;

  assign wr_code = secded_encode(wdata);

  secded_ram_store #(
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W),
    .MODE  (MODE)
  ) u_store (
    .clk      (clk),
    .en       (en),
    .we       (we),
    .addr     (addr),
    .wcode    (wr_code),
    .rst_latch(rst_latch),
    .rcode    (arr_code)
  );

  secded_ram_pipe #(
    .PIPE_EN(PIPE_EN)
  ) u_pipe (
    .clk(clk),
    .ce (pipe_ce),
    .d  (arr_code),
    .q  (dec_in_code)
  );

  secded_ram_decout #(
    .OUT_REG(OUT_REG)
  ) u_decout (
    .clk       (clk),
    .rst_out   (rst_out),
    .code      (dec_in_code),
    .rdata     (rdata),
    .err_single(err_single),
    .err_double(err_double)
  );

  generate
    if (PIPE_EN) begin : g_pipe_chk
      // R8: neither reset reaches the pipeline stage
      a_r8_pipe_no_reset: assert property (@(posedge clk) disable iff (1'b0)
        ((rst_latch || rst_out) && !pipe_ce) |=> $stable(dec_in_code));
    end
  endgenerate

endmodule

// File: tb/secded_pipe_ram_bench.sv
module secded_pipe_ram_bench;
  import secded_ram_pkg::*;

  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam int LAT0  = 3;  // pipe + out reg
  localparam int LAT1  = 2;  // out reg only
  localparam int LAT2  = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          en = 0, we = 0, pipe_ce = 1, rst_latch = 1, rst_out = 1;
  logic [AW-1:0] addr = '0;
  logic [63:0]   wdata = '0;
  logic [63:0]   rd0, rd1, rd2;
  logic          s0, s1, s2, d0, d1, d2;

  secded_pipe_ram #(.DEPTH(DEPTH), .PIPE_EN(1'b1), .OUT_REG(1'b1), .MODE(COLL_READ_FIRST))
  u_secded_pipe_ram (.clk(clk), .en(en), .we(we), .addr(addr), .wdata(wdata), .pipe_ce(pipe_ce),
    .rst_latch(rst_latch), .rst_out(rst_out), .rdata(rd0), .err_single(s0), .err_double(d0));

  secded_pipe_ram #(.DEPTH(DEPTH), .PIPE_EN(1'b0), .OUT_REG(1'b1), .MODE(COLL_WRITE_FIRST))
  u_secded_pipe_ram_wf (.clk(clk), .en(en), .we(we), .addr(addr), .wdata(wdata), .pipe_ce(pipe_ce),
    .rst_latch(rst_latch), .rst_out(rst_out), .rdata(rd1), .err_single(s1), .err_double(d1));

  secded_pipe_ram #(.DEPTH(DEPTH), .PIPE_EN(1'b1), .OUT_REG(1'b1), .MODE(COLL_NO_CHANGE))
  u_secded_pipe_ram_nc (.clk(clk), .en(en), .we(we), .addr(addr), .wdata(wdata), .pipe_ce(pipe_ce),
    .rst_latch(rst_latch), .rst_out(rst_out), .rdata(rd2), .err_single(s2), .err_double(d2));

  typedef struct {
    int          due;
    logic [63:0] d;
    logic        s;
    logic        e;
    string       tag;
  } exp_t;

  exp_t q0[$], q1[$], q2[$];
  int vectors = 0, miscompares = 0, cyc = 0;
  bit done = 0;

  logic [63:0] mem_m   [DEPTH];
  bit          valid_m [DEPTH];
  int          kind_m  [DEPTH];
  logic [63:0] dmask_m [DEPTH];
  exp_t        nc_last;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, bit ok, logic [65:0] act, logic [65:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  task automatic cmp(int dut, exp_t e, logic [63:0] d, logic s, logic x);
    check($sformatf("%s dut%0d", e.tag, dut),
          (e.due == cyc) && (d === e.d) && (s === e.s) && (x === e.e),
          {d, s, x}, {e.d, e.s, e.e});
  endtask

  // Monitor: pop expectations as results arrive
  always @(negedge clk) begin
    if (q0.size() > 0 && q0[0].due <= cyc) cmp(0, q0.pop_front(), rd0, s0, d0);
    if (q1.size() > 0 && q1[0].due <= cyc) cmp(1, q1.pop_front(), rd1, s1, d1);
    if (q2.size() > 0 && q2[0].due <= cyc) cmp(2, q2.pop_front(), rd2, s2, d2);
  end

  // Position p (not a power of two) carries data bit p - 2 - floor(log2 p)
  function automatic int data_idx(int p);
    return p - 2 - $clog2(p + 1) + 1;
  endfunction

  function automatic exp_t model_rd(int dut, int a, string tag);
    exp_t e;
    e.tag = tag;
    e.d = mem_m[a];
    e.s = 0;
    e.e = 0;
    if (dut == 0) begin
      if (kind_m[a] == 1) e.s = 1;
      if (kind_m[a] == 2) begin
        e.e = 1;
        e.d = mem_m[a] ^ dmask_m[a];
      end
    end
    return e;
  endfunction

  // Driver: apply one access and predict all three results
  task automatic op(bit w, int a, logic [63:0] d, string tag);
    exp_t e0, e1, e2;
    @(negedge clk);
    en = 1; we = w; addr = AW'(a); wdata = d;
    if (!w) begin
      e0 = model_rd(0, a, tag);
      e1 = model_rd(1, a, tag);
      e2 = model_rd(2, a, tag);
      nc_last = e2;
      e0.due = cyc + LAT0; q0.push_back(e0);
      e1.due = cyc + LAT1; q1.push_back(e1);
      e2.due = cyc + LAT2; q2.push_back(e2);
    end else begin
      if (valid_m[a]) begin
        e0 = model_rd(0, a, "R2 read-first");
        e0.due = cyc + LAT0; q0.push_back(e0);
      end
      e1.d = d; e1.s = 0; e1.e = 0; e1.tag = "R3 write-first";
      e1.due = cyc + LAT1; q1.push_back(e1);
      e2 = nc_last; e2.tag = "R4 no-change";
      e2.due = cyc + LAT2; q2.push_back(e2);
      mem_m[a] = d; valid_m[a] = 1; kind_m[a] = 0; dmask_m[a] = '0;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      en = 0; we = 0;
    end
  endtask

  task automatic flip(int a, int p);
    u_secded_pipe_ram.u_store.mem_q[a][p] = ~u_secded_pipe_ram.u_store.mem_q[a][p];
  endtask

  initial begin
    #2_000_000;
    vectors++;
    miscompares++;
    $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [63:0] xw;
    for (int i = 0; i < DEPTH; i++) begin
      valid_m[i] = 0; kind_m[i] = 0; dmask_m[i] = '0; mem_m[i] = '0;
    end
    nc_last.d = '0; nc_last.s = 0; nc_last.e = 0; nc_last.tag = "R4";
    // Reset state: R9 latch zero, R10 output zero
    repeat (3) @(negedge clk);
    check("R10 reset dut0", {rd0, s0, d0} == '0, {rd0, s0, d0}, '0);
    check("R10 reset dut1", {rd1, s1, d1} == '0, {rd1, s1, d1}, '0);
    check("R9 reset dut2",  {rd2, s2, d2} == '0, {rd2, s2, d2}, '0);
    rst_latch = 0; rst_out = 0;

    // R1/R3/R4 writes of several patterns
    for (int i = 0; i < 8; i++)
      op(1, i, {32'hA5A5_0000 + 32'(i), 32'h0F0F_F0F0 ^ (32'h1 << (i * 3))}, "R1");
    op(1, 8, 64'hFFFF_FFFF_FFFF_FFFF, "R1");
    op(1, 15, 64'h0000_0000_0000_0001, "R1");
    // R1 back-to-back reads, latency per pipeline setting
    for (int i = 0; i < 9; i++) op(0, i, '0, "R1 read");
    op(0, 15, '0, "R1 read top address");
    // R2/R3/R4 overwrite of a written address, then reread
    op(1, 3, 64'hDEAD_BEEF_0123_4567, "R2");
    op(0, 3, '0, "R1 reread");
    // R11: idle gap, then a read still lines up
    idle(2);
    op(0, 8, '0, "R11 after idle");
    idle(6);

    // Backdoor corruption on dut0
    flip(1, 9);  kind_m[1] = 1;
    flip(2, 0);  kind_m[2] = 1;
    flip(4, 2);  kind_m[4] = 1;
    flip(7, 71); kind_m[7] = 1;
    flip(5, 3); flip(5, 5); kind_m[5] = 2;
    dmask_m[5] = (64'h1 << data_idx(3)) | (64'h1 << data_idx(5));
    flip(6, 0); flip(6, 70); kind_m[6] = 2;
    dmask_m[6] = 64'h1 << data_idx(70);
    op(0, 1, '0, "R5 data bit");
    op(0, 2, '0, "R5 overall parity bit");
    op(0, 4, '0, "R5 hamming bit");
    op(0, 7, '0, "R5 top data bit");
    op(0, 5, '0, "R6 two data bits");
    op(0, 6, '0, "R6 parity plus data");
    op(0, 0, '0, "R1 clean neighbour");
    op(0, 5, '0, "R6 repeat");
    // write over corrupted word: read-first returns flagged old word
    op(1, 5, 64'h1357_9BDF_2468_ACE0, "R2");
    op(0, 5, '0, "R1 after rewrite");
    idle(8);
    check("R1 queues drained", (q0.size() + q1.size() + q2.size()) == 0,
          66'(q0.size() + q1.size() + q2.size()), '0);

    // Directed: pipeline hold across resets (dut0 pipe, dut1 no pipe)
    xw = mem_m[0];
    @(negedge clk); en = 1; we = 0; addr = '0; pipe_ce = 1;
    idle(3);
    check("R7 pipelined read", {rd0, s0, d0} == {xw, 2'b00}, {rd0, s0, d0}, {xw, 2'b00});
    pipe_ce = 0; rst_latch = 1; rst_out = 1;
    @(negedge clk);
    check("R10 out cleared dut0", {rd0, s0, d0} == '0, {rd0, s0, d0}, '0);
    check("R10 out cleared dut1", {rd1, s1, d1} == '0, {rd1, s1, d1}, '0);
    rst_latch = 0; rst_out = 0;
    @(negedge clk);
    check("R8 pipe kept through reset", {rd0, s0, d0} == {xw, 2'b00}, {rd0, s0, d0}, {xw, 2'b00});
    check("R9 latch cleared dut1", {rd1, s1, d1} == '0, {rd1, s1, d1}, '0);
    @(negedge clk);
    check("R7 pipe held ce low", {rd0, s0, d0} == {xw, 2'b00}, {rd0, s0, d0}, {xw, 2'b00});
    pipe_ce = 1;
    @(negedge clk);
    @(negedge clk);
    check("R7 pipe loads cleared latch", {rd0, s0, d0} == '0, {rd0, s0, d0}, '0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule